// File: doc/BRIEF.md
# Conversion Launch Sequencer

This block decides when one digital filter starts a conversion and which input channel that conversion samples. It runs two launch paths side by side. The regular path converts one selected channel. It is started by a software pulse or by the start strobe of the master filter, and it runs either once per start or back to back until continuous operation is switched off. The injected path converts channels taken from an enable mask. It is started by a software pulse, by an edge on an external trigger line chosen by index, or by the master start strobe. Per launch event it converts either the whole mask in ascending order (scan) or only the next channel of a rotating round.

The data path is modelled only as a fixed conversion time of `CONV_CYCLES` clocks. The block emits a one-cycle start strobe with the channel and the path. When the conversion time has elapsed it emits an end-of-conversion pulse for the path that owns the result. Injected work takes precedence over regular work, but only at a conversion boundary: a running conversion is never cut short, and a pending or continuous regular conversion resumes once the injected sequence has drained. Dropping the enable input aborts everything.

Top module: `launch_seq`

## Requirements
- R1: While `enable_i` is low no start strobe and no end-of-conversion pulse appears. Lowering it aborts the conversion in flight (its end pulse never comes), drops all pending work of both paths, and restarts the injected rotation at the lowest enabled channel. After reset all outputs are low.
- R2: A software start sampled at clock edge N on an idle block gives `start_o` high for exactly one cycle after edge N+1. The matching end pulse is high for one cycle, `CONV_CYCLES` clocks after the start strobe. Consecutive starts are at least `CONV_CYCLES` clocks apart.
- R3: With `reg_cont_i` low, one regular software start gives exactly one regular conversion of channel `reg_ch_i` (`start_inj_o` low).
- R4: With `reg_cont_i` high, regular conversions repeat every `CONV_CYCLES` clocks. Once it is lowered, they stop after at most one more launch.
- R5: With `FILTER_ID` not 0, a pulse on `master_start_i` acts as a regular start when `reg_sync_en_i` is high and as an injected launch event when `inj_sync_en_i` is high. With both enables low it has no effect.
- R6: With `inj_scan_i` high, one injected launch event converts every channel set in `inj_ch_mask_i`, lowest index first, back to back.
- R7: With `inj_scan_i` low, each injected launch event converts exactly one channel. This is the lowest enabled channel not yet converted in the current round, and the round restarts at the lowest enabled channel once all have been converted.
- R8: `trig_edge_i` selects the external trigger qualification: 0 no trigger, 1 rising edge, 2 falling edge, 3 both edges of the selected line.
- R9: `trig_sel_i` picks trigger line by index. Lines other than the selected one produce no launch. A selected index whose bit in `TRIG_USED` is 0 (default: only 0 to 8 and 26 to 28 are in use) produces no launch.
- R10: An injected launch event that arrives while an injected sequence still has a conversion queued or in flight is ignored.
- R11: An injected launch that arrives during regular conversions starts at the next conversion boundary, ahead of pending regular work. Regular conversions resume after the injected sequence.
- R12: `reg_eoc_o` pulses only for regular conversions and `inj_eoc_o` only for injected ones. The two never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Filter enable; low aborts and clears |
| reg_sw_start_i | input | 1 | Regular software start pulse |
| reg_cont_i | input | 1 | Regular continuous operation |
| reg_sync_en_i | input | 1 | Regular path follows master start |
| reg_ch_i | input | CH_W | Regular channel index |
| inj_sw_start_i | input | 1 | Injected software launch pulse |
| inj_sync_en_i | input | 1 | Injected path follows master start |
| inj_scan_i | input | 1 | 1 scan whole mask, 0 rotate one channel |
| inj_ch_mask_i | input | NUM_CH | Injected channel enable mask |
| trig_edge_i | input | 2 | Trigger edge mode (0 off, 1 rise, 2 fall, 3 both) |
| trig_sel_i | input | SEL_W | External trigger line index |
| trig_lines_i | input | NUM_TRIG | Asynchronous external trigger lines |
| master_start_i | input | 1 | Start strobe of the master filter |
| start_o | output | 1 | One-cycle conversion start strobe |
| start_ch_o | output | CH_W | Channel of the current start |
| start_inj_o | output | 1 | Current start belongs to the injected path |
| reg_eoc_o | output | 1 | Regular end-of-conversion pulse |
| inj_eoc_o | output | 1 | Injected end-of-conversion pulse |

## Verification
The checker assumes that `inj_ch_mask_i` does not change while an injected sequence is queued or in flight, so that every injected start names a channel of the live mask. It also assumes `CONV_CYCLES` is at least 2. The bench changes the mask, scan mode, edge mode and trigger selection only when both paths are idle. It changes the trigger selection only while all trigger lines are low, so a new selection never produces an edge by itself. Master and trigger stimuli are spaced wider than one conversion sequence unless a test sets out to hit the busy window.

// File: rtl/launch_seq_pkg.sv
package launch_seq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef enum logic {
    PATH_REG = 1'b0,
    PATH_INJ = 1'b1
  } path_e;

endpackage

// File: rtl/launch_trig_detect.sv
module launch_trig_detect
  import launch_seq_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 32,
  parameter int unsigned SEL_W    = 5,
  parameter logic [NUM_TRIG-1:0] TRIG_USED = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] lines_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [1:0]          mode_i,
  output logic                hit_o
);

  logic [NUM_TRIG-1:0] meta_q, sync_q;
  logic                lvl, prev_q;
  edge_mode_e          mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= lines_i;
      sync_q <= meta_q;
      prev_q <= lvl;
    end
  end

  // unused or out-of-range index reads as a constant low line
  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel_i == SEL_W'(i)) lvl = sync_q[i] & TRIG_USED[i];
    end
  end

  assign mode = edge_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit_o = lvl & ~prev_q;
      EDGE_FALL: hit_o = ~lvl & prev_q;
      EDGE_BOTH: hit_o = lvl ^ prev_q;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/launch_inj_sched.sv
module launch_inj_sched #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              evt_i,
  input  logic              scan_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              inflight_i,
  input  logic              take_i,
  output logic              pending_o,
  output logic [CH_W-1:0]   next_ch_o
);

  logic [NUM_CH-1:0] todo_q, done_q;
  logic [NUM_CH-1:0] cand, pool, pick, todo_low;
  logic              wrap, busy;

  assign busy     = (|todo_q) | inflight_i;
  assign cand     = mask_i & ~done_q;
  assign wrap     = ~|cand;
  assign pool     = wrap ? mask_i : cand;
  assign pick     = pool & (~pool + NUM_CH'(1));
  assign todo_low = todo_q & (~todo_q + NUM_CH'(1));

  always_comb begin
    next_ch_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (todo_low[i]) next_ch_o = CH_W'(i);
    end
  end

  assign pending_o = |todo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      todo_q <= '0;
      done_q <= '0;
    end else if (!enable_i) begin
      todo_q <= '0;
      done_q <= '0;
    end else if (take_i) begin
      todo_q <= todo_q & ~todo_low;
    end else if (evt_i && !busy && (|mask_i)) begin
      if (scan_i) begin
        todo_q <= mask_i;
      end else begin
        todo_q <= pick;
        done_q <= (wrap ? '0 : done_q) | pick;
      end
    end
  end

endmodule

// File: rtl/launch_ctrl.sv
module launch_ctrl
  import launch_seq_pkg::*;
#(
  parameter int unsigned CH_W        = 3,
  parameter int unsigned CONV_CYCLES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            reg_evt_i,
  input  logic            reg_cont_i,
  input  logic [CH_W-1:0] reg_ch_i,
  input  logic            inj_pend_i,
  input  logic [CH_W-1:0] inj_ch_i,
  output logic            inj_take_o,
  output logic            inj_inflight_o,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic            start_inj_o,
  output logic            reg_eoc_o,
  output logic            inj_eoc_o
);

  localparam int unsigned CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

  logic             reg_pend_q, active_q;
  path_e            kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             boundary, last, take_reg, take_any;

  assign last       = active_q && (cnt_q == '0);
  assign boundary   = !active_q || last;
  assign inj_take_o = enable_i && boundary && inj_pend_i;
  assign take_reg   = enable_i && boundary && !inj_pend_i && reg_pend_q;
  assign take_any   = inj_take_o || take_reg;
  assign inj_inflight_o = active_q && (kind_q == PATH_INJ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_pend_q <= 1'b0;
    end else if (!enable_i) begin
      reg_pend_q <= 1'b0;
    end else if (take_reg) begin
      reg_pend_q <= reg_cont_i | reg_evt_i;
    end else if (reg_evt_i) begin
      reg_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      kind_q      <= PATH_REG;
      cnt_q       <= '0;
      start_o     <= 1'b0;
      start_ch_o  <= '0;
      start_inj_o <= 1'b0;
      reg_eoc_o   <= 1'b0;
      inj_eoc_o   <= 1'b0;
    end else if (!enable_i) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      start_o   <= 1'b0;
      reg_eoc_o <= 1'b0;
      inj_eoc_o <= 1'b0;
    end else begin
      start_o   <= take_any;
      reg_eoc_o <= last && (kind_q == PATH_REG);
      inj_eoc_o <= last && (kind_q == PATH_INJ);
      if (take_any) begin
        active_q    <= 1'b1;
        kind_q      <= inj_take_o ? PATH_INJ : PATH_REG;
        cnt_q       <= CNT_W'(CONV_CYCLES - 1);
        start_ch_o  <= inj_take_o ? inj_ch_i : reg_ch_i;
        start_inj_o <= inj_take_o;
      end else if (active_q) begin
        if (last) active_q <= 1'b0;
        else      cnt_q    <= cnt_q - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/launch_seq.sv
module launch_seq #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned NUM_TRIG    = 32,
  parameter int unsigned CONV_CYCLES = 4,
  parameter int unsigned FILTER_ID   = 1,
  parameter logic [NUM_TRIG-1:0] TRIG_USED = 32'h1C00_01FF,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                reg_sw_start_i,
  input  logic                reg_cont_i,
  input  logic                reg_sync_en_i,
  input  logic [CH_W-1:0]     reg_ch_i,
  input  logic                inj_sw_start_i,
  input  logic                inj_sync_en_i,
  input  logic                inj_scan_i,
  input  logic [NUM_CH-1:0]   inj_ch_mask_i,
  input  logic [1:0]          trig_edge_i,
  input  logic [SEL_W-1:0]    trig_sel_i,
  input  logic [NUM_TRIG-1:0] trig_lines_i,
  input  logic                master_start_i,
  output logic                start_o,
  output logic [CH_W-1:0]     start_ch_o,
  output logic                start_inj_o,
  output logic                reg_eoc_o,
  output logic                inj_eoc_o
);

  logic sync_hit, ext_hit, reg_evt, inj_evt;
  logic inj_pend, inj_take, inj_inflight;
  logic [CH_W-1:0] inj_ch;

  // the master filter has nobody to follow
  generate
    if (FILTER_ID == 0) begin : g_master
      assign sync_hit = 1'b0;
    end else begin : g_slave
      assign sync_hit = master_start_i;
    end
  endgenerate

  launch_trig_detect #(
    .NUM_TRIG (NUM_TRIG),
    .SEL_W    (SEL_W),
    .TRIG_USED(TRIG_USED)
  ) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines_i(trig_lines_i),
    .sel_i  (trig_sel_i),
    .mode_i (trig_edge_i),
    .hit_o  (ext_hit)
  );

  assign reg_evt = reg_sw_start_i | (reg_sync_en_i & sync_hit);
  assign inj_evt = inj_sw_start_i | ext_hit | (inj_sync_en_i & sync_hit);

  launch_inj_sched #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) u_inj (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .evt_i     (inj_evt),
    .scan_i    (inj_scan_i),
    .mask_i    (inj_ch_mask_i),
    .inflight_i(inj_inflight),
    .take_i    (inj_take),
    .pending_o (inj_pend),
    .next_ch_o (inj_ch)
  );

  launch_ctrl #(
    .CH_W       (CH_W),
    .CONV_CYCLES(CONV_CYCLES)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .reg_evt_i     (reg_evt),
    .reg_cont_i    (reg_cont_i),
    .reg_ch_i      (reg_ch_i),
    .inj_pend_i    (inj_pend),
    .inj_ch_i      (inj_ch),
    .inj_take_o    (inj_take),
    .inj_inflight_o(inj_inflight),
    .start_o       (start_o),
    .start_ch_o    (start_ch_o),
    .start_inj_o   (start_inj_o),
    .reg_eoc_o     (reg_eoc_o),
    .inj_eoc_o     (inj_eoc_o)
  );

endmodule

// File: rtl/launch_seq_chk.sv
module launch_seq_chk #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned CH_W        = 3,
  parameter int unsigned CONV_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic [NUM_CH-1:0] inj_ch_mask_i,
  input logic              start_o,
  input logic [CH_W-1:0]   start_ch_o,
  input logic              start_inj_o,
  input logic              reg_eoc_o,
  input logic              inj_eoc_o
);

  localparam int unsigned GAP_W = $clog2(CONV_CYCLES + 1) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             last_inj_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= GAP_W'(CONV_CYCLES);
      last_inj_q <= 1'b0;
    end else begin
      if (start_o) last_inj_q <= start_inj_o;
      if (!enable_i)                        gap_q <= GAP_W'(CONV_CYCLES);
      else if (start_o)                     gap_q <= '0;
      else if (gap_q < GAP_W'(CONV_CYCLES)) gap_q <= gap_q + GAP_W'(1);
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!start_o && !reg_eoc_o && !inj_eoc_o));

  p_start_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (gap_q >= GAP_W'(CONV_CYCLES - 1)));

  p_inj_ch_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && start_inj_o) |-> inj_ch_mask_i[start_ch_o]);

  p_eoc_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_eoc_o, inj_eoc_o}));

  p_inj_eoc_owner_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_eoc_o |-> last_inj_q);

  p_reg_eoc_owner_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_eoc_o |-> !last_inj_q);

endmodule

bind launch_seq launch_seq_chk #(
  .NUM_CH     (NUM_CH),
  .CH_W       (CH_W),
  .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .inj_ch_mask_i(inj_ch_mask_i),
  .start_o      (start_o),
  .start_ch_o   (start_ch_o),
  .start_inj_o  (start_inj_o),
  .reg_eoc_o    (reg_eoc_o),
  .inj_eoc_o    (inj_eoc_o)
);

// File: tb/tb_launch_seq.sv
module tb_launch_seq;

  localparam int NUM_CH = 8;
  localparam int NUM_TRIG = 32;
  localparam int C = 4;
  localparam int CH_W = 3;
  localparam int SEL_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable, reg_sw, reg_cont, reg_sync, inj_sw, inj_sync, inj_scan, master;
  logic [CH_W-1:0] reg_ch;
  logic [NUM_CH-1:0] mask;
  logic [1:0] edge_mode;
  logic [SEL_W-1:0] sel;
  logic [NUM_TRIG-1:0] lines;
  logic start, start_inj, reg_eoc, inj_eoc;
  logic [CH_W-1:0] start_ch;

  always #4 clk = ~clk;

  launch_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .reg_sw_start_i(reg_sw), .reg_cont_i(reg_cont), .reg_sync_en_i(reg_sync),
    .reg_ch_i(reg_ch), .inj_sw_start_i(inj_sw), .inj_sync_en_i(inj_sync),
    .inj_scan_i(inj_scan), .inj_ch_mask_i(mask), .trig_edge_i(edge_mode),
    .trig_sel_i(sel), .trig_lines_i(lines), .master_start_i(master),
    .start_o(start), .start_ch_o(start_ch), .start_inj_o(start_inj),
    .reg_eoc_o(reg_eoc), .inj_eoc_o(inj_eoc)
  );

  int cyc = 0;
  int n_checks = 0, n_fail = 0;
  int n_start = 0, n_reg_eoc = 0, n_inj_eoc = 0;
  int log_ch[64], log_inj[64], log_cyc[64];
  int reg_eoc_cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start && n_start < 64) begin
        log_ch[n_start]  = int'(start_ch);
        log_inj[n_start] = int'(start_inj);
        log_cyc[n_start] = cyc;
        n_start++;
      end
      if (reg_eoc) begin n_reg_eoc++; reg_eoc_cyc = cyc; end
      if (inj_eoc) n_inj_eoc++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    n_start = 0; n_reg_eoc = 0; n_inj_eoc = 0;
  endtask

  task automatic pulse_reg(output int at);
    @(negedge clk); reg_sw = 1; at = cyc;
    @(negedge clk); reg_sw = 0;
  endtask

  task automatic pulse_inj();
    @(negedge clk); inj_sw = 1;
    @(negedge clk); inj_sw = 0;
  endtask

  task automatic pulse_master();
    @(negedge clk); master = 1;
    @(negedge clk); master = 0;
  endtask

  task automatic toggle_line(input int idx);
    @(negedge clk); lines[idx] = 1'b1;
    idle(12);
    lines[idx] = 1'b0;
    idle(12);
  endtask

  task automatic t_reset();
    check("R1 reset start_o", int'(start), 0);
    check("R1 reset eoc", int'(reg_eoc | inj_eoc), 0);
  endtask

  task automatic t_reg_single();
    int p;
    clr(); reg_ch = 3'd3;
    pulse_reg(p);
    idle(20);
    check("R3 single start count", n_start, 1);
    check("R3 channel", log_ch[0], 3);
    check("R3 regular path", log_inj[0], 0);
    check("R2 start latency", log_cyc[0] - p, 2);
    check("R2 eoc delay", reg_eoc_cyc - log_cyc[0], C);
    check("R12 reg eoc count", n_reg_eoc, 1);
    check("R12 no inj eoc", n_inj_eoc, 0);
  endtask

  task automatic t_reg_cont();
    int p, n1, bad;
    clr(); reg_ch = 3'd5; reg_cont = 1;
    pulse_reg(p);
    idle(13);
    reg_cont = 0;
    idle(20);
    n1 = n_start;
    idle(20);
    check("R4 stops after cont cleared", n_start, n1);
    check("R4 repeated", int'(n1 >= 3), 1);
    bad = 0;
    for (int i = 1; i < n1; i++) if (log_cyc[i] - log_cyc[i-1] != C) bad++;
    check("R4 spacing", bad, 0);
  endtask

  task automatic t_inj_scan();
    clr(); mask = 8'b1010_0100; inj_scan = 1;
    pulse_inj();
    idle(25);
    check("R6 scan count", n_start, 3);
    check("R6 first ch", log_ch[0], 2);
    check("R6 second ch", log_ch[1], 5);
    check("R6 third ch", log_ch[2], 7);
    check("R6 injected path", log_inj[0] + log_inj[1] + log_inj[2], 3);
    check("R12 inj eoc count", n_inj_eoc, 3);
    check("R12 no reg eoc", n_reg_eoc, 0);
  endtask

  task automatic t_busy();
    clr();
    pulse_inj();
    idle(3);
    pulse_inj();
    idle(25);
    check("R10 retrigger ignored", n_start, 3);
  endtask

  task automatic t_rotation();
    int exp_ch[5] = '{2, 5, 7, 2, 5};
    inj_scan = 0;
    @(negedge clk); enable = 0; idle(2); enable = 1;
    clr();
    for (int i = 0; i < 5; i++) begin pulse_inj(); idle(12); end
    check("R7 rotation count", n_start, 5);
    for (int i = 0; i < 5; i++) check("R7 rotation ch", log_ch[i], exp_ch[i]);
  endtask

  task automatic t_disable();
    clr();
    @(negedge clk); enable = 0; idle(2); enable = 1;
    pulse_inj(); idle(12);
    check("R1 rotation restarts lowest", log_ch[0], 2);
    inj_scan = 1;
    clr();
    pulse_inj();
    idle(2);
    enable = 0;
    idle(3);
    enable = 1;
    idle(20);
    check("R1 abort stops sequence", n_start, 1);
    check("R1 aborted eoc suppressed", n_inj_eoc, 0);
  endtask

  task automatic t_edges();
    int exp_n[4] = '{0, 1, 1, 2};
    mask = 8'h01; inj_scan = 0; sel = 5'd4;
    for (int m = 0; m < 4; m++) begin
      edge_mode = 2'(m);
      idle(3);
      clr();
      toggle_line(4);
      check("R8 edge mode starts", n_start, exp_n[m]);
    end
  endtask

  task automatic t_select();
    edge_mode = 2'd1; sel = 5'd4; idle(3);
    clr(); toggle_line(5);
    check("R9 other line ignored", n_start, 0);
    sel = 5'd10; idle(3);
    clr(); toggle_line(10);
    check("R9 unused index ignored", n_start, 0);
    sel = 5'd26; idle(3);
    clr(); toggle_line(26);
    check("R9 used index 26 fires", n_start, 1);
    edge_mode = 2'd0;
  endtask

  task automatic t_sync();
    clr(); reg_ch = 3'd1; reg_sync = 1;
    pulse_master(); idle(12);
    check("R5 reg sync start", n_start, 1);
    check("R5 reg sync path", log_inj[0], 0);
    reg_sync = 0;
    clr(); pulse_master(); idle(12);
    check("R5 sync disabled", n_start, 0);
    mask = 8'h10; inj_scan = 1; inj_sync = 1;
    clr(); pulse_master(); idle(12);
    check("R5 inj sync start", n_start, 1);
    check("R5 inj sync ch", log_ch[0], 4);
    inj_sync = 0;
  endtask

  task automatic t_priority();
    int p, fi;
    reg_ch = 3'd6; reg_cont = 1; mask = 8'b0000_0011; inj_scan = 1;
    clr();
    pulse_reg(p);
    idle(5);
    pulse_inj();
    idle(14);
    reg_cont = 0;
    idle(20);
    fi = -1;
    for (int i = 0; i < n_start; i++) if (fi < 0 && log_inj[i] == 1) fi = i;
    check("R11 injected seen", int'(fi >= 1), 1);
    if (fi >= 1 && fi + 2 < n_start) begin
      check("R11 boundary not cut", log_cyc[fi] - log_cyc[fi-1], C);
      check("R11 inj ch0", log_ch[fi], 0);
      check("R11 inj ch1 next", log_ch[fi+1] * 2 + log_inj[fi+1], 3);
      check("R11 regular resumes", log_ch[fi+2] * 2 + log_inj[fi+2], 12);
    end else begin
      check("R11 sequence length", n_start, fi + 3);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    enable = 1; reg_sw = 0; reg_cont = 0; reg_sync = 0; inj_sw = 0;
    inj_sync = 0; inj_scan = 0; master = 0; reg_ch = '0; mask = '0;
    edge_mode = 2'd0; sel = '0; lines = '0;
    idle(3);
    t_reset();
    rst_n = 1;
    idle(3);
    t_reset();
    t_reg_single();
    t_reg_cont();
    t_inj_scan();
    t_busy();
    t_rotation();
    t_disable();
    t_edges();
    t_select();
    t_sync();
    t_priority();
    done = 1;
    summary();
    $finish;
  end

endmodule